// File: doc/BRIEF.md
# Byte-Oriented SPI Slave with Buffered Data

This block is an SPI slave that runs on a fast system clock. The external clock, data-in and select pins pass through synchronizers, and the slave detects the external clock edges in the system clock domain. Bytes move most-significant bit first in clock mode 0: the slave samples MOSI on a rising SCK edge and changes MISO after a falling SCK edge. The SCK frequency must be at most one quarter of the system clock.

The host sees a register-style port. A write sends a byte to the transmit side. If the shift register is empty, the byte goes straight into it. Otherwise the byte waits in a one-entry holding register until the shift register frees up at the end of a byte, and a further write while the holding register is occupied is refused. Received bytes land in a one-entry receive buffer, and a byte that arrives while that buffer is unread is dropped. Three sticky flags report these events: byte complete, write collision and receive overrun. The host clears each flag with its own strobe, and the flags are merged into one interrupt line.

A mode input selects how the slave is addressed. With the select pin in use (4-wire), the slave takes part only while NSS is low, and each falling edge of NSS restarts the bit count. With the select pin ignored (3-wire), the slave takes part whenever it is enabled, and only dropping the enable restarts the bit count.

Top module: `spi_byte_slave`

## Requirements
- R1: MOSI is sampled on each rising SCK edge, MSB first. After the eighth rising edge the byte sits in the receive buffer (on `rd_data_o`), `rx_full_o` is 1 and `flag_done_o` is 1.
- R2: MISO carries the transmit byte MSB first. The MSB is valid before the first rising edge, and each later bit appears after a falling edge. When no byte has been loaded, the slave shifts out zeros.
- R3: A host write while the shift register is empty loads that register directly, so the byte goes out in the next transfer.
- R4: A host write while the shift register is occupied parks the byte in the holding register. The byte moves to the shift register at the eighth rising edge of the current or next transfer, and it goes out in the transfer after that.
- R5: A host write while the holding register is occupied is discarded and sets `flag_wcol_o`.
- R6: A byte that completes while `rx_full_o` is 1 is dropped. The buffered byte stays on `rd_data_o` and `flag_ovr_o` is set.
- R7: In 4-wire mode (`mode4_i`=1), SCK edges are ignored while NSS is high, and a falling edge of NSS restarts the bit count.
- R8: In 3-wire mode (`mode4_i`=0), NSS has no effect. Only driving `en_i` low restarts the bit count.
- R9: Each flag stays at 1 until its clear strobe is pulsed. A read strobe clears `rx_full_o` but leaves `flag_done_o` set.
- R10: `irq_o` is 1 exactly when `irq_en_i` is 1 and at least one flag is set.
- R11: `miso_oe_o` is 1 only while the slave is selected: enabled with NSS low in 4-wire mode, or enabled in 3-wire mode.
- R12: After reset all flags, `rx_full_o`, `irq_o` and `miso_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | External serial clock |
| mosi_i | input | 1 | Serial data from the master |
| nss_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO |
| en_i | input | 1 | Slave enable |
| mode4_i | input | 1 | 1 = select pin used, 0 = select pin ignored |
| irq_en_i | input | 1 | Interrupt enable |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_i | input | 1 | Host read strobe (frees the receive buffer) |
| rd_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| clr_done_i | input | 1 | Clear byte-complete flag |
| clr_wcol_i | input | 1 | Clear write-collision flag |
| clr_ovr_i | input | 1 | Clear overrun flag |
| flag_done_o | output | 1 | Byte-complete flag |
| flag_wcol_o | output | 1 | Write-collision flag |
| flag_ovr_o | output | 1 | Receive-overrun flag |
| irq_o | output | 1 | Merged interrupt |

## Verification
Some properties are checked on every cycle. Flags stay set until cleared, a refused write leaves the holding register untouched, an overrun leaves the receive buffer untouched, the holding register empties only at a byte boundary, and a disabled slave keeps its bit count at zero. Other behaviour only the bench scenarios can show: the order of bytes on MISO across the shift and holding registers, the bit-count restart by the select pin versus the enable, and the select pin having no effect in 3-wire mode.

// File: rtl/spis_pkg.sv
package spis_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic {
        WIRE3 = 1'b0,
        WIRE4 = 1'b1
    } wire_mode_e;

    typedef struct packed {
        logic done;
        logic wcol;
        logic ovr;
    } flags_t;

    function automatic logic link_active(input logic en, input wire_mode_e m,
                                         input logic nss);
        return en && (m == WIRE3 || !nss);
    endfunction
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [STAGES-1:0][N-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spis_xfer.sv
module spis_xfer
    import spis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  wire_mode_e mode_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       nss_i,
    input  logic       wr_i,
    input  byte_t      wdata_i,
    input  logic       rd_i,
    output byte_t      rdata_o,
    output logic       rx_full_o,
    output logic       miso_o,
    output logic       miso_oe_o,
    output flags_t     evt_o
);
    logic [CNT_W-1:0] cnt;
    byte_t rx_sh, rx_buf, tx_sh, tx_buf;
    logic  sh_full, tx_full, rx_full;
    logic  sck_prev, nss_prev;

    logic  active, sck_rise, sck_fall, nss_fall, cnt_clear;
    logic  take, last, shift_out, sh_free, wr_ok;
    byte_t rx_byte;

    always_comb begin
        active    = link_active(en_i, mode_i, nss_i);
        sck_rise  = sck_i && !sck_prev;
        sck_fall  = !sck_i && sck_prev;
        nss_fall  = !nss_i && nss_prev;
        cnt_clear = !en_i || (mode_i == WIRE4 && nss_fall);
        take      = active && sck_rise;
        last      = take && cnt == CNT_W'(DATA_W - 1);
        shift_out = active && sck_fall && cnt != '0;
        sh_free   = !sh_full || (last && !tx_full);
        wr_ok     = wr_i && !tx_full;
        rx_byte   = {rx_sh[DATA_W-2:0], mosi_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rx_sh    <= '0;
            rx_buf   <= '0;
            rx_full  <= 1'b0;
            tx_sh    <= '0;
            tx_buf   <= '0;
            tx_full  <= 1'b0;
            sh_full  <= 1'b0;
            sck_prev <= 1'b0;
            nss_prev <= 1'b1;
        end else begin
            sck_prev <= sck_i;
            nss_prev <= nss_i;

            if (cnt_clear)  cnt <= '0;
            else if (take)  cnt <= cnt + CNT_W'(1);

            if (take) rx_sh <= rx_byte;
            if (last && !rx_full) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (rd_i) begin
                rx_full <= 1'b0;
            end

            if (wr_ok && sh_free) begin
                tx_sh   <= wdata_i;
                sh_full <= 1'b1;
            end else begin
                if (last) begin
                    if (tx_full) begin
                        tx_sh   <= tx_buf;
                        tx_full <= 1'b0;
                        sh_full <= 1'b1;
                    end else begin
                        tx_sh   <= '0;
                        sh_full <= 1'b0;
                    end
                end else if (shift_out) begin
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
                if (wr_ok) begin
                    tx_buf  <= wdata_i;
                    tx_full <= 1'b1;
                end
            end
        end
    end

    assign rdata_o   = rx_buf;
    assign rx_full_o = rx_full;
    assign miso_o    = tx_sh[DATA_W-1];
    assign miso_oe_o = active;
    assign evt_o     = '{done: last, wcol: wr_i && tx_full, ovr: last && rx_full};

    // R5
    wcol_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && tx_full) |=> $stable(tx_buf));
    // R4
    hold_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_full) |-> $past(last));
    // R6
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (last && rx_full) |=> $stable(rx_buf));
    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> cnt == '0);
endmodule

// File: rtl/spis_flags.sv
module spis_flags
    import spis_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_i,
    input  flags_t clr_i,
    input  logic   irq_en_i,
    output flags_t flags_o,
    output logic   irq_o
);
    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= set_i | (flags_q & ~clr_i);
    end

    assign flags_o = flags_q;
    assign irq_o   = irq_en_i && (|flags_q);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.done && !clr_i.done) |=> flags_q.done);
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.ovr && !clr_i.ovr) |=> flags_q.ovr);
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              nss_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              en_i,
    input  logic              mode4_i,
    input  logic              irq_en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rx_full_o,
    input  logic              clr_done_i,
    input  logic              clr_wcol_i,
    input  logic              clr_ovr_i,
    output logic              flag_done_o,
    output logic              flag_wcol_o,
    output logic              flag_ovr_o,
    output logic              irq_o
);
    logic [2:0] pins_s;
    flags_t     evt, flags, clr;

    spis_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({nss_i, mosi_i, sck_i}),
        .q_o (pins_s)
    );

    spis_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .mode_i    (wire_mode_e'(mode4_i)),
        .sck_i     (pins_s[0]),
        .mosi_i    (pins_s[1]),
        .nss_i     (pins_s[2]),
        .wr_i      (wr_i),
        .wdata_i   (wr_data_i),
        .rd_i      (rd_i),
        .rdata_o   (rd_data_o),
        .rx_full_o (rx_full_o),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o),
        .evt_o     (evt)
    );

    assign clr = '{done: clr_done_i, wcol: clr_wcol_i, ovr: clr_ovr_i};

    spis_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_i    (evt),
        .clr_i    (clr),
        .irq_en_i (irq_en_i),
        .flags_o  (flags),
        .irq_o    (irq_o)
    );

    assign flag_done_o = flags.done;
    assign flag_wcol_o = flags.wcol;
    assign flag_ovr_o  = flags.ovr;
endmodule

// File: tb/test_spi_byte_slave.sv
module test_spi_byte_slave;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, mosi = 1'b0, nss = 1'b1;
    logic en = 1'b0, mode4 = 1'b1, irq_en = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic clr_done = 1'b0, clr_wcol = 1'b0, clr_ovr = 1'b0;
    logic miso, miso_oe, rx_full, f_done, f_wcol, f_ovr, irq;
    logic [7:0] rdata;
    int checks = 0, fails = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    spi_byte_slave i_spi_byte_slave (
        .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .nss_i(nss),
        .miso_o(miso), .miso_oe_o(miso_oe), .en_i(en), .mode4_i(mode4),
        .irq_en_i(irq_en), .wr_i(wr), .wr_data_i(wdata), .rd_i(rd),
        .rd_data_o(rdata), .rx_full_o(rx_full), .clr_done_i(clr_done),
        .clr_wcol_i(clr_wcol), .clr_ovr_i(clr_ovr), .flag_done_o(f_done),
        .flag_wcol_o(f_wcol), .flag_ovr_o(f_ovr), .irq_o(irq)
    );

    // columns: host byte to send, byte the master shifts in
    localparam logic [15:0] VEC [5] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                        16'h81_7E, 16'h6D_B2};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h, expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] b);
        wr = 1'b1; wdata = b; tick(1); wr = 1'b0; tick(1);
    endtask

    task automatic host_read();
        rd = 1'b1; tick(1); rd = 1'b0; tick(1);
    endtask

    task automatic clear_all();
        clr_done = 1'b1; clr_wcol = 1'b1; clr_ovr = 1'b1; tick(1);
        clr_done = 1'b0; clr_wcol = 1'b0; clr_ovr = 1'b0; tick(1);
    endtask

    task automatic select(input logic v);
        nss = v; tick(4);
    endtask

    task automatic shift(input logic [7:0] m, input int nbits,
                         output logic [7:0] q);
        q = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi = m[7-i];
            tick(4);
            q = {q[6:0], miso};
            sck = 1'b1; tick(4);
            sck = 1'b0; tick(4);
        end
        tick(4);
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R12 reset state
        check("R12 flags", {f_done, f_wcol, f_ovr}, 3'b000);
        check("R12 rx_full", rx_full, 0);
        check("R12 irq", irq, 0);
        check("R12 miso_oe", miso_oe, 0);

        en = 1'b1; mode4 = 1'b1; tick(4);
        check("R11 oe with nss high", miso_oe, 0);

        // R1 R2 R3 table walk
        foreach (VEC[k]) begin
            host_write(VEC[k][15:8]);
            select(1'b0);
            check("R11 oe with nss low", miso_oe, 1);
            shift(VEC[k][7:0], 8, got);
            select(1'b1);
            check("R2 R3 miso byte", got, VEC[k][15:8]);
            check("R1 rx byte", rdata, VEC[k][7:0]);
            check("R1 done and full", {f_done, rx_full}, 2'b11);
            host_read();
            check("R9 read keeps done", {f_done, rx_full}, 2'b10);
            clear_all();
            check("R9 done cleared", f_done, 0);
        end

        // R4 R5 holding register and collision
        host_write(8'h11);
        host_write(8'h22);
        check("R4 no collision", f_wcol, 0);
        host_write(8'h33);
        check("R5 collision flag", f_wcol, 1);
        select(1'b0);
        shift(8'h00, 8, got);
        check("R3 first byte", got, 8'h11);
        host_read();
        shift(8'h00, 8, got);
        check("R4 held byte", got, 8'h22);
        host_read();
        shift(8'h00, 8, got);
        check("R5 R2 refused byte dropped, zeros", got, 8'h00);
        host_read();
        check("R9 wcol sticky", f_wcol, 1);
        clear_all();
        check("R9 wcol cleared", f_wcol, 0);

        // R6 overrun
        shift(8'h5A, 8, got);
        shift(8'hC3, 8, got);
        check("R6 old byte kept", rdata, 8'h5A);
        check("R6 overrun flag", f_ovr, 1);
        // R10 interrupt gating
        check("R10 irq masked", irq, 0);
        irq_en = 1'b1; tick(1);
        check("R10 irq raised", irq, 1);
        host_read();
        clear_all();
        check("R10 irq dropped", irq, 0);
        select(1'b1);

        // R7 NSS high ignores SCK, NSS fall restarts count
        shift(8'hFF, 8, got);
        check("R7 ignored while deselected", {f_done, rx_full}, 2'b00);
        select(1'b0);
        shift(8'hF0, 3, got);
        select(1'b1);
        select(1'b0);
        shift(8'h96, 8, got);
        check("R7 count restart", rdata, 8'h96);
        host_read();
        clear_all();
        select(1'b1);

        // R8 3-wire: select pin ignored
        mode4 = 1'b0; tick(4);
        check("R11 oe in 3-wire", miso_oe, 1);
        shift(8'h4B, 8, got);
        check("R8 byte with nss high", rdata, 8'h4B);
        host_read();
        clear_all();
        shift(8'hA0, 3, got);
        select(1'b0);
        select(1'b1);
        shift(8'hC8, 5, got);
        check("R8 nss does not restart", rdata, 8'hB9);
        host_read();
        clear_all();
        shift(8'hE0, 3, got);
        en = 1'b0; tick(4);
        check("R11 oe disabled", miso_oe, 0);
        en = 1'b1; tick(4);
        shift(8'h3D, 8, got);
        check("R8 enable restart", rdata, 8'h3D);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule